// File: doc/BRIEF.md
# VME Block Transfer Sequencer with Address-Boundary Splitting

This block runs one VME block transfer for a local requester that already owns the bus. It takes a start address, a byte count, the transfer width (32-bit BLT or 64-bit multiplexed MBLT) and a fixed-address flag. It then drives the address strobe, the address counter and the data strobe one beat at a time. Each beat ends when the slave answers with DTACK or BERR.

The block opens a new address phase when the address counter reaches a block boundary: every 256 bytes for BLT and every 2048 bytes for MBLT. It does this by dropping the address strobe for one cycle and raising it again with the new address. Bus ownership is never given up. In fixed-address (FIFO) mode the address does not move and no boundary split happens.

Requests that are misaligned or malformed are refused and no bus cycle starts. When a transfer ends, the block gives a one-cycle done pulse, the termination kind and the number of bytes actually moved.

Top module: `vme_blt_seq`

## Requirements
- R1: After reset, `as_o`, `ds_o`, `busy_o` and `done_o` are all low.
- R2: A well-formed request moves exactly `byte_cnt` bytes, in beats of 4 bytes (BLT, `mblt=0`) or 8 bytes (MBLT, `mblt=1`). It ends with `term_o` = 2'b00 and `moved_o` = `byte_cnt`.
- R3: Outside FIFO mode, beat i is issued with `addr_o` = start + i × beat size. `as_o` is dropped for at least one cycle and raised again each time the next beat's address is a multiple of the block size (256 for BLT, 2048 for MBLT). No split happens after the final beat.
- R4: In FIFO mode (`fifo=1`), every beat uses the start address and the whole transfer is a single address phase.
- R5: A request is refused with `term_o` = 2'b10, `moved_o` = 0 and no `as_o` assertion in any of these cases: the start address is not a multiple of the beat size, the byte count is not a multiple of the beat size, or the byte count is zero.
- R6: BERR on a beat ends the transfer at once. `term_o` becomes 2'b01, and `moved_o` counts only the beats that were acknowledged with DTACK before it.
- R7: `ds_o` is raised only when both DTACK and BERR are low. It is raised only while `as_o` is high.
- R8: `done_o` is high for exactly one cycle per accepted `start`. `term_o` and `moved_o` are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, sampled while idle |
| start_addr | input | AW | First byte address |
| byte_cnt | input | CW | Number of bytes to move |
| mblt | input | 1 | 1 = 64-bit multiplexed block transfer, 0 = 32-bit block transfer |
| fifo | input | 1 | 1 = hold the address fixed and never split |
| dtack | input | 1 | Slave data acknowledge |
| berr | input | 1 | Slave bus error |
| as_o | output | 1 | Address strobe |
| ds_o | output | 1 | Data strobe |
| addr_o | output | AW | Current beat address |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| term_o | output | 2 | 00 normal, 01 bus error, 10 refused |
| moved_o | output | CW | Bytes acknowledged |

## Verification
Two events can meet in the same handshake step. The beat that crosses a block boundary can also be the last beat, and a bus error can arrive on the first beat after a split. The first case is provoked by an MBLT request that ends exactly on a 2048-byte boundary; it is judged by counting address-strobe rises, which must total one. The second case is provoked by injecting BERR on the beat just after a 256-byte split; it is judged by requiring two address phases, a bus-error termination and a moved count that covers only the two acknowledged beats.

// File: rtl/vme_blt_seq.sv
module vme_blt_seq #(
  parameter int AW       = 32,
  parameter int CW       = 16,
  parameter int BLT_BLK  = 256,
  parameter int MBLT_BLK = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] byte_cnt,
  input  logic          mblt,
  input  logic          fifo,
  input  logic          dtack,
  input  logic          berr,
  output logic          as_o,
  output logic          ds_o,
  output logic [AW-1:0] addr_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    term_o,
  output logic [CW-1:0] moved_o
);
  localparam logic [1:0] T_OK = 2'b00, T_BERR = 2'b01, T_REJ = 2'b10;
  localparam logic [AW-1:0] BLT_MASK  = AW'(BLT_BLK - 1);
  localparam logic [AW-1:0] MBLT_MASK = AW'(MBLT_BLK - 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_DATA, S_REL, S_GAP, S_FIN} st_t;
  st_t st;

  logic [AW-1:0] addr_q;
  logic [CW-1:0] left_q, moved_q;
  logic          mblt_q, fifo_q;
  logic [1:0]    term_q;
  logic [3:0]    step;
  logic          bad, at_bnd, bus_quiet;

  assign step      = mblt_q ? 4'd8 : 4'd4;
  assign bus_quiet = !dtack && !berr;
  assign at_bnd    = (addr_q & (mblt_q ? MBLT_MASK : BLT_MASK)) == '0;
  assign bad       = (byte_cnt == '0)
                   || (mblt ? (|start_addr[2:0] || |byte_cnt[2:0])
                            : (|start_addr[1:0] || |byte_cnt[1:0]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      moved_q <= '0;
      mblt_q  <= 1'b0;
      fifo_q  <= 1'b0;
      term_q  <= T_OK;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          mblt_q  <= mblt;
          fifo_q  <= fifo;
          addr_q  <= start_addr;
          left_q  <= byte_cnt;
          moved_q <= '0;
          term_q  <= bad ? T_REJ : T_OK;
          st      <= bad ? S_FIN : S_ADDR;
        end
        S_ADDR: if (bus_quiet) st <= S_DATA;
        S_DATA: begin
          if (berr) begin
            term_q <= T_BERR;
            st     <= S_FIN;
          end else if (dtack) begin
            left_q  <= left_q - CW'(step);
            moved_q <= moved_q + CW'(step);
            if (!fifo_q) addr_q <= addr_q + AW'(step);
            st <= S_REL;
          end
        end
        S_REL: if (bus_quiet) begin
          if (left_q == '0)           st <= S_FIN;
          else if (!fifo_q && at_bnd) st <= S_GAP;
          else                        st <= S_DATA;
        end
        S_GAP:   st <= S_ADDR;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign as_o    = (st == S_ADDR) || (st == S_DATA) || (st == S_REL);
  assign ds_o    = (st == S_DATA);
  assign addr_o  = addr_q;
  assign busy_o  = (st != S_IDLE);
  assign done_o  = (st == S_FIN);
  assign term_o  = term_q;
  assign moved_o = moved_q;

  a_r7_ds_inside_as: assert property (@(posedge clk) disable iff (!rst_n)
    ds_o |-> as_o);
  a_r7_ds_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ds_o) |-> $past(!dtack && !berr));
  a_r3_rearm_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(as_o) && $past(busy_o)) |-> ((addr_o & (mblt_q ? MBLT_MASK : BLT_MASK)) == '0));
  a_r4_fifo_addr_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && fifo_q && !done_o) |-> $stable(addr_o));
  a_r5_refused_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && term_o == T_REJ) |-> (!$past(as_o) && moved_o == '0));
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r6_berr_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_o && berr) |=> (done_o && term_o == T_BERR && !as_o));
endmodule

// File: tb/sim_vme_blt_seq.sv
module sim_vme_blt_seq;
  logic        clk = 0, rst_n = 0, start = 0, mblt = 0, fifo = 0;
  logic [31:0] start_addr = 0;
  logic [15:0] byte_cnt = 0;
  logic        dtack = 0, berr = 0;
  logic        as_o, ds_o, busy_o, done_o;
  logic [31:0] addr_o;
  logic [1:0]  term_o;
  logic [15:0] moved_o;

  always #2 clk = ~clk;

  vme_blt_seq u0 (.clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_cnt(byte_cnt), .mblt(mblt), .fifo(fifo), .dtack(dtack), .berr(berr),
    .as_o(as_o), .ds_o(ds_o), .addr_o(addr_o), .busy_o(busy_o), .done_o(done_o),
    .term_o(term_o), .moved_o(moved_o));

  int checks = 0, errors = 0;
  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor and slave responder
  logic       clr = 0;
  logic [7:0] berr_at = 8'hFF;
  int  phases, beats, bad_addr, bad_ds;
  logic as_p, ds_p;
  logic [3:0] dly;
  always @(negedge clk) begin
    if (clr) begin
      phases = 0; beats = 0; bad_addr = 0; bad_ds = 0; dly = 0;
      dtack = 0; berr = 0;
    end else begin
      if (as_o && !as_p) phases++;
      if (ds_o && !ds_p) begin
        if (dtack || berr) bad_ds++;
        if (addr_o != (fifo ? start_addr : start_addr + 32'(beats) * (mblt ? 8 : 4)))
          bad_addr++;
        beats++;
      end
      dly = {dly[2:0], ds_o};
      dtack = dly[1] && (beats != int'(berr_at) + 1);
      berr  = dly[1] && (beats == int'(berr_at) + 1);
    end
    as_p = as_o; ds_p = ds_o;
  end

  localparam int NV = 13;
  localparam logic [31:0] VA [NV] = '{32'h100, 32'h1F8, 32'h7F0, 32'h0F0, 32'h1F0, 32'h040,
    32'h102, 32'h104, 32'h100, 32'h7F8, 32'h0F8, 32'h000, 32'h7F8};
  localparam logic [15:0] VC [NV] = '{16, 16, 32, 40, 528, 32, 16, 16, 6, 8, 16, 0, 24};
  localparam logic        VM [NV] = '{0, 0, 1, 0, 0, 0, 0, 1, 0, 1, 0, 0, 1};
  localparam logic        VF [NV] = '{0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1};
  localparam logic [7:0]  VB [NV] = '{255, 255, 255, 255, 255, 3, 255, 255, 255, 255, 2, 255, 255};
  localparam logic [1:0]  XT [NV] = '{0, 0, 0, 0, 0, 1, 2, 2, 2, 0, 1, 2, 0};
  localparam int          XM [NV] = '{16, 16, 32, 40, 528, 12, 0, 0, 0, 8, 8, 0, 24};
  localparam int          XP [NV] = '{1, 2, 2, 1, 3, 1, 0, 0, 0, 1, 2, 0, 1};

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clr = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 as", as_o, 0); chk("R1 ds", ds_o, 0);
    chk("R1 busy", busy_o, 0); chk("R1 done", done_o, 0);
    for (int v = 0; v < NV; v++) begin
      clr = 1;
      start_addr = VA[v]; byte_cnt = VC[v]; mblt = VM[v]; fifo = VF[v]; berr_at = VB[v];
      @(negedge clk);
      clr = 0; start = 1;
      @(negedge clk);
      start = 0;
      for (int w = 0; w < 3000 && !done_o; w++) @(negedge clk);
      chk($sformatf("R8 done v%0d", v), done_o, 1);
      chk($sformatf("R2/R5/R6 term v%0d", v), term_o, XT[v]);
      chk($sformatf("R2/R6 moved v%0d", v), moved_o, XM[v]);
      chk($sformatf("R3/R4 phases v%0d", v), phases, XP[v]);
      chk($sformatf("R3/R4 addr v%0d", v), bad_addr, 0);
      chk($sformatf("R7 ds release v%0d", v), bad_ds, 0);
      @(negedge clk);
      chk($sformatf("R8 single v%0d", v), done_o, 0);
      chk($sformatf("R8 idle v%0d", v), busy_o, 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule